// File: doc/BRIEF.md
# Front-End Crosstalk Burst Filter

This block sits behind the readout of a drift-chamber front-end and marks hits that look like electrical crosstalk. Crosstalk appears as a burst: several channels of one 8-channel amplifier chip fire at almost the same time. The block receives one event as a stream of hits. Each hit carries a board number, a channel number on that board (48 channels, six chips of eight), a TDC count and a hit index. A marker closes the event.

After the marker the block forms one group per (board, chip). It orders each group by TDC and searches for the largest run of at least four consecutive ordered hits whose TDC spread is within a fixed window. Every hit in that run is flagged. After a fixed number of cycles it returns a flag vector indexed by hit index, together with a one-cycle done strobe. A control bit, sampled at the end marker, turns the filter on. When the bit is low, every flag is zero.

Top module: `xtalk_filter`

## Requirements
- R1: After reset `flags_o` is all zero and `done_o` is low.
- R2: A hit's chip number is its channel divided by 8. Only hits with the same board and the same chip number can form a burst together.
- R3: A hit with board number 500 or above, or with channel 48 or above, is discarded and is never flagged.
- R4: A (board, chip) group with fewer than 4 accepted hits is never flagged. Any non-zero `flags_o` at done has at least 4 bits set.
- R5: A run qualifies when its largest TDC minus its smallest TDC is at most 16. A spread of 16 qualifies and a spread of 17 does not.
- R6: In each group, the qualifying run with the most hits is chosen. All of its hits are flagged and the other hits of the group are not.
- R7: Among qualifying runs of equal size, the run that starts lowest in TDC order is chosen. Equal TDC values are ordered by arrival.
- R8: `filter_en` is sampled in the cycle of the end marker. If it is 0, `flags_o` is all zero for that event.
- R9: Bit i of `flags_o` belongs to the hit sent with `hit_idx` = i. Indices not sent in the event read 0.
- R10: `done_o` is high for exactly one cycle. It rises after the 17th rising edge counted from the edge that accepts the end marker (MAX_HITS+1 edges). `flags_o` then holds until the next end marker.
- R11: At most 8 hits per (board, chip) and 16 hits per event are kept. Later hits beyond either limit are discarded.
- R12: Hits presented between the end marker and `done_o` are ignored and do not reach the next event.
- R13: A hit presented in the same cycle as the end marker belongs to the event that the marker closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| filter_en | input | 1 | Filter enable, sampled at the end marker |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_board | input | 9 | Front-end board number |
| hit_chan | input | 6 | Channel number on the board |
| hit_tdc | input | 12 | TDC count of the hit |
| hit_idx | input | 4 | Position of the hit in the event, selects its flag bit |
| hit_last | input | 1 | End-of-event marker |
| flags_o | output | 16 | Crosstalk flag per hit index |
| done_o | output | 1 | One-cycle strobe: flags for the event are ready |

## Verification
A wrong group key or a wrong fill count changes which hits share a chip. It shows at the first done strobe as a flag vector whose set bits cross chip boundaries, or as a vector with one to three set bits. A wrong ordering or run-selection state shows as a vector that names the wrong run. Such a vector differs from the arithmetic model in the same event. A stuck scan cursor or phase shows as a done strobe that arrives early, late or never, and the bench detects this within the 17 expected edges. Capture left open during the scan shows as extra flags in the next, otherwise empty, event.

// File: rtl/xtalk_pkg.sv
// Shared widths and types of the crosstalk burst filter.
// Assumes boards fit in 9 bits and the chip number fits in 3 bits.
package xtalk_pkg;
    localparam int BOARD_W = 9;
    localparam int CHAN_W  = 6;
    localparam int ASIC_W  = 3;

    typedef struct packed {
        logic [BOARD_W-1:0] board;
        logic [ASIC_W-1:0]  asic;
    } grp_key_t;

    typedef enum logic { PH_GATHER, PH_SCAN } phase_t;
endpackage

// File: rtl/xtalk_hit_store.sv
// Event hit store. Captures accepted hits in arrival order. A hit is dropped
// when its board or chip number is out of range, when its (board, chip)
// group already holds PER_ASIC_MAX hits, or when the store is full.
// Assumes clr and cap_en are never high together with a wanted capture.
module xtalk_hit_store
    import xtalk_pkg::*;
#(
    parameter int MAX_HITS        = 16,
    parameter int PER_ASIC_MAX    = 8,
    parameter int BOARD_LIMIT     = 500,
    parameter int ASICS_PER_BOARD = 6,
    parameter int CH_PER_ASIC     = 8,
    parameter int TDC_W           = 12,
    parameter int IDX_W           = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic                 clr,
    input  logic                 in_valid,
    input  logic [BOARD_W-1:0]   in_board,
    input  logic [CHAN_W-1:0]    in_chan,
    input  logic [TDC_W-1:0]     in_tdc,
    input  logic [IDX_W-1:0]     in_idx,
    output logic [MAX_HITS-1:0]  ent_valid,
    output grp_key_t             ent_key [MAX_HITS],
    output logic [TDC_W-1:0]     ent_tdc [MAX_HITS],
    output logic [IDX_W-1:0]     ent_idx [MAX_HITS]
);
    localparam int CNT_W = $clog2(MAX_HITS + 1);
    localparam int PTR_W = $clog2(MAX_HITS);

    logic [CHAN_W-1:0] asic_full;
    logic              in_range;
    grp_key_t          new_key;
    logic [CNT_W-1:0]  same_cnt;
    logic [CNT_W-1:0]  fill;
    logic              take;

    // Decode the chip number and check both ranges.
    always_comb begin
        asic_full     = in_chan / CHAN_W'(CH_PER_ASIC);
        in_range      = (in_board < BOARD_W'(BOARD_LIMIT)) &&
                        (asic_full < CHAN_W'(ASICS_PER_BOARD));
        new_key.board = in_board;
        new_key.asic  = asic_full[ASIC_W-1:0];
    end

    // Count stored hits that already belong to the incoming hit's group.
    always_comb begin
        same_cnt = '0;
        for (int j = 0; j < MAX_HITS; j++) begin
            if (ent_valid[j] && ent_key[j] == new_key)
                same_cnt = same_cnt + CNT_W'(1);
        end
    end

    assign take = cap_en && in_valid && in_range &&
                  (fill < CNT_W'(MAX_HITS)) && (same_cnt < CNT_W'(PER_ASIC_MAX));

    // Append an accepted hit at the fill pointer; clear between events.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ent_valid <= '0;
            fill      <= '0;
        end else if (take) begin
            ent_valid[fill[PTR_W-1:0]] <= 1'b1;
            ent_key[fill[PTR_W-1:0]]   <= new_key;
            ent_tdc[fill[PTR_W-1:0]]   <= in_tdc;
            ent_idx[fill[PTR_W-1:0]]   <= in_idx;
            fill                       <= fill + CNT_W'(1);
        end
    end

    p_fill_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |=> (fill == $past(fill) + CNT_W'(1)));

    p_fill_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(MAX_HITS)) |=> (fill == CNT_W'(MAX_HITS) || fill == '0));
endmodule

// File: rtl/xtalk_cluster_eval.sv
// Combinational burst decision for one stored hit (the anchor). Ranks all
// members of the anchor's group by (TDC, arrival). For each member it counts
// how many ordered members lie within WINDOW of it, taking that member as the
// run start. It picks the longest run, the lowest start on ties, and reports
// whether the anchor falls inside the picked run.
// Assumes at most MAX_HITS entries; cost grows with MAX_HITS squared.
module xtalk_cluster_eval
    import xtalk_pkg::*;
#(
    parameter int MAX_HITS    = 16,
    parameter int TDC_W       = 12,
    parameter int WINDOW      = 16,
    parameter int MIN_CLUSTER = 4
) (
    input  logic [MAX_HITS-1:0]          ent_valid,
    input  grp_key_t                     ent_key [MAX_HITS],
    input  logic [TDC_W-1:0]             ent_tdc [MAX_HITS],
    input  logic [$clog2(MAX_HITS)-1:0]  anchor,
    output logic                         in_burst
);
    localparam int CNT_W = $clog2(MAX_HITS + 1);

    logic [MAX_HITS-1:0] member;
    logic [CNT_W-1:0]    rank  [MAX_HITS];
    logic [CNT_W-1:0]    reach [MAX_HITS];
    logic [CNT_W-1:0]    best_n;
    logic [CNT_W-1:0]    best_k;

    // Select the entries that share the anchor's (board, chip) group.
    always_comb begin
        for (int j = 0; j < MAX_HITS; j++)
            member[j] = ent_valid[j] && (ent_key[j] == ent_key[anchor]);
    end

    // Ordered position of each member and its in-window run length.
    always_comb begin
        for (int j = 0; j < MAX_HITS; j++) begin
            rank[j]  = '0;
            reach[j] = '0;
            for (int m = 0; m < MAX_HITS; m++) begin
                if (member[m]) begin
                    if (ent_tdc[m] < ent_tdc[j] || (ent_tdc[m] == ent_tdc[j] && m < j))
                        rank[j] = rank[j] + CNT_W'(1);
                    else if ((ent_tdc[m] - ent_tdc[j]) <= TDC_W'(WINDOW))
                        reach[j] = reach[j] + CNT_W'(1);
                end
            end
        end
    end

    // Longest run wins; among equal lengths the lowest start wins.
    always_comb begin
        best_n = '0;
        best_k = '0;
        for (int j = 0; j < MAX_HITS; j++) begin
            if (member[j] && (reach[j] > best_n ||
                              (reach[j] == best_n && rank[j] < best_k))) begin
                best_n = reach[j];
                best_k = rank[j];
            end
        end
    end

    // The anchor is flagged when it lies inside a run of at least MIN_CLUSTER.
    assign in_burst = member[anchor] && (best_n >= CNT_W'(MIN_CLUSTER)) &&
                      (rank[anchor] >= best_k) && (rank[anchor] < best_k + best_n);
endmodule

// File: rtl/xtalk_filter.sv
// Crosstalk burst filter top. Gathers an event's hits until hit_last. It then
// scans the stored hits one per cycle, sets the flag bit of each hit that
// lies in its group's chosen burst, and pulses done_o. The flags hold until
// the next end marker.
// Assumes hit indices are unique within an event; hits are ignored while
// the scan runs.
module xtalk_filter
    import xtalk_pkg::*;
#(
    parameter int MAX_HITS        = 16,
    parameter int PER_ASIC_MAX    = 8,
    parameter int BOARD_LIMIT     = 500,
    parameter int ASICS_PER_BOARD = 6,
    parameter int CH_PER_ASIC     = 8,
    parameter int TDC_W           = 12,
    parameter int WINDOW          = 16,
    parameter int MIN_CLUSTER     = 4,
    localparam int IDX_W          = $clog2(MAX_HITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                filter_en,
    input  logic                hit_valid,
    input  logic [8:0]          hit_board,
    input  logic [5:0]          hit_chan,
    input  logic [TDC_W-1:0]    hit_tdc,
    input  logic [IDX_W-1:0]    hit_idx,
    input  logic                hit_last,
    output logic [MAX_HITS-1:0] flags_o,
    output logic                done_o
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(MAX_HITS - 1);

    phase_t              phase;
    logic [IDX_W-1:0]    cursor;
    logic                en_lat;
    logic                scan_end;
    logic                in_burst;
    logic [MAX_HITS-1:0] ent_valid;
    grp_key_t            ent_key [MAX_HITS];
    logic [TDC_W-1:0]    ent_tdc [MAX_HITS];
    logic [IDX_W-1:0]    ent_idx [MAX_HITS];

    assign scan_end = (phase == PH_SCAN) && (cursor == LAST_SLOT);

    xtalk_hit_store #(
        .MAX_HITS(MAX_HITS), .PER_ASIC_MAX(PER_ASIC_MAX), .BOARD_LIMIT(BOARD_LIMIT),
        .ASICS_PER_BOARD(ASICS_PER_BOARD), .CH_PER_ASIC(CH_PER_ASIC),
        .TDC_W(TDC_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .cap_en(phase == PH_GATHER), .clr(scan_end),
        .in_valid(hit_valid), .in_board(hit_board), .in_chan(hit_chan),
        .in_tdc(hit_tdc), .in_idx(hit_idx),
        .ent_valid(ent_valid), .ent_key(ent_key), .ent_tdc(ent_tdc), .ent_idx(ent_idx)
    );

    xtalk_cluster_eval #(
        .MAX_HITS(MAX_HITS), .TDC_W(TDC_W), .WINDOW(WINDOW), .MIN_CLUSTER(MIN_CLUSTER)
    ) u_eval (
        .ent_valid(ent_valid), .ent_key(ent_key), .ent_tdc(ent_tdc),
        .anchor(cursor), .in_burst(in_burst)
    );

    // Phase control, scan cursor and flag accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_GATHER;
            cursor  <= '0;
            en_lat  <= 1'b0;
            flags_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (phase)
                PH_GATHER: begin
                    if (hit_last) begin
                        phase   <= PH_SCAN;
                        cursor  <= '0;
                        en_lat  <= filter_en;
                        flags_o <= '0;
                    end
                end
                PH_SCAN: begin
                    if (en_lat && ent_valid[cursor] && in_burst)
                        flags_o[ent_idx[cursor]] <= 1'b1;
                    if (cursor == LAST_SLOT) begin
                        phase  <= PH_GATHER;
                        done_o <= 1'b1;
                    end else begin
                        cursor <= cursor + IDX_W'(1);
                    end
                end
                default: phase <= PH_GATHER;
            endcase
        end
    end

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_GATHER && !hit_last) |=> $stable(flags_o));

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !en_lat) |-> (flags_o == '0));

    p_burst_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flags_o == '0 || $countones(flags_o) >= MIN_CLUSTER));

    p_cursor_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SCAN && cursor != LAST_SLOT) |=> (cursor == $past(cursor) + IDX_W'(1)));
endmodule

// File: tb/xtalk_filter_test.sv
module xtalk_filter_test;
    localparam int N   = 16;
    localparam int LAT = N + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        filter_en = 1'b0;
    logic        hit_valid = 1'b0;
    logic [8:0]  hit_board = '0;
    logic [5:0]  hit_chan = '0;
    logic [11:0] hit_tdc = '0;
    logic [3:0]  hit_idx = '0;
    logic        hit_last = 1'b0;
    logic [15:0] flags_o;
    logic        done_o;

    int tests = 0;
    int fails = 0;

    int eb [N];
    int ec [N];
    int et [N];

    logic [31:0] lfsr = 32'h1234_5678;

    xtalk_filter uut (
        .clk(clk), .rst_n(rst_n), .filter_en(filter_en), .hit_valid(hit_valid),
        .hit_board(hit_board), .hit_chan(hit_chan), .hit_tdc(hit_tdc),
        .hit_idx(hit_idx), .hit_last(hit_last), .flags_o(flags_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // Arithmetic model: capture rules, then a size-downward, start-upward search.
    function automatic logic [15:0] model(input int n, input bit en);
        int acc [N];
        int na = 0;
        logic [15:0] res = '0;
        for (int i = 0; i < n; i++) begin
            int same = 0;
            if (eb[i] < 500 && ec[i] / 8 < 6 && na < N) begin
                for (int q = 0; q < na; q++)
                    if (eb[acc[q]] == eb[i] && ec[acc[q]] / 8 == ec[i] / 8) same++;
                if (same < 8) begin
                    acc[na] = i;
                    na++;
                end
            end
        end
        if (!en) return '0;
        for (int p = 0; p < na; p++) begin
            int grp [N];
            int cnt = 0;
            bit found = 0;
            for (int q = 0; q < na; q++)
                if (eb[acc[q]] == eb[acc[p]] && ec[acc[q]] / 8 == ec[acc[p]] / 8) begin
                    grp[cnt] = acc[q];
                    cnt++;
                end
            for (int a = 1; a < cnt; a++)
                for (int b = a; b > 0 && et[grp[b-1]] > et[grp[b]]; b--) begin
                    int tmp = grp[b];
                    grp[b] = grp[b-1];
                    grp[b-1] = tmp;
                end
            for (int sz = cnt; sz >= 4 && !found; sz--)
                for (int k = 0; k + sz <= cnt && !found; k++)
                    if (et[grp[k+sz-1]] - et[grp[k]] <= 16) begin
                        for (int l = k; l < k + sz; l++) res[grp[l]] = 1'b1;
                        found = 1;
                    end
        end
        return res;
    endfunction

    task automatic set_hit(input int i, input int b, input int c, input int t);
        eb[i] = b;
        ec[i] = c;
        et[i] = t;
    endtask

    // Sends hits 0..n-1 (hit_idx = i), closes the event, waits for done.
    task automatic run_event(input int n, input bit en, input bit last_with_hit,
                             input bit inject, output logic [15:0] got, output int lat);
        filter_en = en;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hit_valid = 1'b1;
            hit_board = 9'(eb[i]);
            hit_chan  = 6'(ec[i]);
            hit_tdc   = 12'(et[i]);
            hit_idx   = 4'(i);
            hit_last  = last_with_hit && (i == n - 1);
        end
        if (!last_with_hit || n == 0) begin
            @(negedge clk);
            hit_valid = 1'b0;
            hit_last  = 1'b1;
        end
        @(negedge clk);
        hit_valid = 1'b0;
        hit_last  = 1'b0;
        lat = 1;
        while (!done_o && lat < 60) begin
            hit_valid = inject && lat <= 4;
            hit_board = 9'd0;
            hit_chan  = 6'(lat);
            hit_tdc   = 12'd0;
            hit_idx   = 4'(9 + lat);
            @(negedge clk);
            lat++;
        end
        hit_valid = 1'b0;
        got = flags_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] got;
        int lat;

        repeat (3) @(negedge clk);
        check("R1 flags after reset", 32'(flags_o), 32'h0);
        check("R1 done after reset", 32'(done_o), 32'h0);
        rst_n = 1'b1;

        // R5: spread of exactly 16 qualifies.
        set_hit(0, 5, 2, 100); set_hit(1, 5, 0, 116); set_hit(2, 5, 7, 104); set_hit(3, 5, 3, 110);
        run_event(4, 1, 0, 0, got, lat);
        check("R5 spread 16", 32'(got), 32'h000F);
        check("R10 latency", 32'(lat), 32'(LAT));
        @(negedge clk);
        check("R10 done single cycle", 32'(done_o), 32'h0);
        repeat (5) @(negedge clk);
        check("R10 flags held", 32'(flags_o), 32'h000F);

        // R5: spread of 17 does not qualify.
        et[1] = 117;
        run_event(4, 1, 0, 0, got, lat);
        check("R5 spread 17", 32'(got), 32'h0);

        // R4: three coincident hits are not enough.
        set_hit(0, 1, 9, 50); set_hit(1, 1, 10, 50); set_hit(2, 1, 11, 51);
        run_event(3, 1, 0, 0, got, lat);
        check("R4 three hits", 32'(got), 32'h0);

        // R6/R7: longest run of five, earliest of the two five-runs.
        set_hit(0, 2, 16, 24); set_hit(1, 2, 17, 0);  set_hit(2, 2, 18, 12); set_hit(3, 2, 19, 26);
        set_hit(4, 2, 20, 8);  set_hit(5, 2, 21, 20); set_hit(6, 2, 22, 4);  set_hit(7, 2, 23, 22);
        run_event(8, 1, 0, 0, got, lat);
        check("R6 longest run", 32'(got), 32'h00B5);

        // R8: same event with the filter disabled.
        run_event(8, 0, 0, 0, got, lat);
        check("R8 disabled", 32'(got), 32'h0);

        // R7: two equal runs, the lower-TDC one wins.
        set_hit(0, 3, 0, 50); set_hit(1, 3, 1, 51); set_hit(2, 3, 2, 52); set_hit(3, 3, 3, 53);
        set_hit(4, 3, 4, 0);  set_hit(5, 3, 5, 1);  set_hit(6, 3, 6, 2);  set_hit(7, 3, 7, 3);
        run_event(8, 1, 0, 0, got, lat);
        check("R7 equal runs", 32'(got), 32'h00F0);

        // R2 and R13: chip boundaries and board boundaries split groups; marker on last hit.
        set_hit(0, 3, 7, 10);  set_hit(1, 3, 8, 10);  set_hit(2, 3, 15, 10); set_hit(3, 3, 16, 10);
        set_hit(4, 3, 40, 10); set_hit(5, 3, 41, 10); set_hit(6, 4, 42, 10); set_hit(7, 4, 43, 10);
        set_hit(8, 6, 24, 30); set_hit(9, 6, 25, 30); set_hit(10, 6, 26, 30); set_hit(11, 6, 31, 46);
        run_event(12, 1, 1, 0, got, lat);
        check("R2 R13 grouping", 32'(got), 32'h0F00);
        check("R13 latency with marker on hit", 32'(lat), 32'(LAT));

        // R3: out-of-range board and channel are discarded; the top of the range is kept.
        set_hit(0, 500, 0, 5); set_hit(1, 500, 1, 5); set_hit(2, 500, 2, 5); set_hit(3, 500, 3, 5);
        set_hit(4, 7, 48, 5);  set_hit(5, 7, 49, 5);  set_hit(6, 7, 50, 5);  set_hit(7, 7, 55, 5);
        set_hit(8, 499, 40, 9); set_hit(9, 499, 41, 9); set_hit(10, 499, 46, 9); set_hit(11, 499, 47, 9);
        run_event(12, 1, 0, 0, got, lat);
        check("R3 range", 32'(got), 32'h0F00);

        // R11: the ninth and tenth hits of one chip are discarded.
        for (int i = 0; i < 10; i++) set_hit(i, 8, i % 8, 5);
        run_event(10, 1, 0, 0, got, lat);
        check("R11 per-chip cap", 32'(got), 32'h00FF);

        // R12: hits injected during the scan must not reach the next event.
        set_hit(0, 0, 1, 0); set_hit(1, 0, 2, 900); set_hit(2, 0, 3, 1800);
        run_event(3, 1, 0, 1, got, lat);
        check("R12 scan event", 32'(got), 32'h0);
        run_event(0, 1, 0, 0, got, lat);
        check("R12 empty follow-up", 32'(got), 32'h0);
        check("R9 empty event", 32'(got), 32'h0);

        // R9/R6 sweep: random events against the model.
        for (int e = 0; e < 400; e++) begin
            int n  = 4 + int'(rnd() % 13);
            bit en = (rnd() % 8) != 0;
            bit lw = rnd() % 2;
            for (int i = 0; i < n; i++) begin
                int bsel = int'(rnd() % 4);
                eb[i] = (bsel == 0) ? 0 : (bsel == 1) ? 1 : (bsel == 2) ? 499 : 500;
                ec[i] = (rnd() % 2 != 0) ? int'(rnd() % 16) : int'(rnd() % 64);
                et[i] = int'(rnd() % 48);
            end
            run_event(n, en, lw, 0, got, lat);
            check("R6 R9 sweep", 32'(got), 32'(model(n, en)));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule